// File: doc/BRIEF.md
# MSI Termination Pending Bank

This block is the landing zone for posted message-signalled interrupt writes. Each write carries a byte offset and a small data word. When the offset names one of the index registers, the data word selects one vector bit in that register, and the block sets that bit. Pending state is held in two levels. There are 16 groups. Each group holds 8 index registers of 16 vector bits. Each group also has a summary word that shows which of its index registers are non-empty.

Each group drives one level-sensitive interrupt line. Service software reads the summary word of a group to find the busy index registers. It then reads each busy index register. The read returns the register's contents and empties it. A write that lands on a register in the same cycle as its read-to-clear is never lost. Writes to the summary words, to unmapped offsets, and with an out-of-range data value have no effect.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every index register is empty, every interrupt line is low, and the read data output is zero.
- R2: Index register x of group n answers at byte offset (n << 19) + (x << 16), for both MSI writes and software reads.
- R3: A valid MSI write to an index register sets the bit whose position equals the write data (0 to 15). A data value of 16 or more changes nothing.
- R4: The summary word of group n reads at byte offset 0x800000 + (n << 16). Its bit x is 1 exactly when index register x of that group holds any set bit. Bits 8 to 15 read as zero.
- R5: A read of an index register returns its contents and empties it, so an immediate second read returns zero.
- R6: Interrupt line n is high in every cycle in which group n has any non-empty index register, and low otherwise. With no MSI write, no line rises.
- R7: When an MSI write and a read hit the same index register in one cycle, the read returns the contents before the write, and the written bit stays pending for the next read.
- R8: MSI writes to a summary offset, to any offset with a nonzero value in bits 15:0, or to any other unmapped offset change no state.
- R9: A read of an unmapped offset returns zero and clears nothing.
- R10: Read data appears on the clock edge after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_wr_valid | input | 1 | MSI write strobe |
| msi_wr_addr | input | 24 | Byte offset of the MSI write |
| msi_wr_data | input | 32 | MSI data, the vector bit number |
| sw_rd_en | input | 1 | Software read request |
| sw_rd_addr | input | 24 | Byte offset of the software read |
| sw_rd_data | output | 16 | Registered read data |
| irq | output | 16 | One level interrupt per group |

## Verification
The checker treats the MSI and read ports as free inputs, so the offsets, data values and same-cycle collisions they accept can all occur. Two properties rest on assumptions about the inputs. The no-rise property assumes that a new pending bit can come only from a write port strobe. The hold property assumes that the read data changes only on a read request. The directed stimulus drives every input on the falling edge and holds it for one full cycle. It reaches the corner cases on purpose: the first and last group, the first and last index, the first and last bit, out-of-range data, low-offset bits set, the summary region, and an exact write/read collision.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

    localparam int DEF_GROUPS  = 16;
    localparam int DEF_IDX     = 8;
    localparam int DEF_VEC     = 16;
    localparam int DEF_SHIFT   = 16;
    localparam int DEF_ADDR_W  = 24;
    localparam int DEF_DATA_W  = 32;

    // Which kind of register an offset names
    typedef enum logic [1:0] {
        REG_NONE    = 2'd0,
        REG_INDEX   = 2'd1,
        REG_SUMMARY = 2'd2
    } reg_kind_e;

    // Decoded target of an access
    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] grp;
        logic [7:0] idx;
    } reg_target_t;

    // Bit position where the summary region starts
    function automatic int region_bit(int shift, int idx_w, int grp_w);
        return shift + idx_w + grp_w;
    endfunction

endpackage

// File: rtl/msi_addr_dec.sv
module msi_addr_dec
    import msi_term_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int GROUPS = DEF_GROUPS,
    parameter int IDX    = DEF_IDX,
    parameter int SHIFT  = DEF_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_target_t       tgt
);
    localparam int GRP_W = $clog2(GROUPS);
    localparam int IDX_W = $clog2(IDX);
    localparam int TOP   = region_bit(SHIFT, IDX_W, GRP_W);

    logic hi_zero, lo_zero, mid_zero;

    always_comb begin
        hi_zero  = (addr >> (TOP + 1)) == '0;
        lo_zero  = addr[SHIFT-1:0] == '0;
        mid_zero = addr[SHIFT+GRP_W +: IDX_W] == '0;
        tgt      = '{kind: REG_NONE, grp: 8'd0, idx: 8'd0};
        if (hi_zero && lo_zero) begin
            if (!addr[TOP]) begin
                tgt.kind = REG_INDEX;
                tgt.grp  = 8'(addr[SHIFT+IDX_W +: GRP_W]);
                tgt.idx  = 8'(addr[SHIFT +: IDX_W]);
            end else if (mid_zero) begin
                tgt.kind = REG_SUMMARY;
                tgt.grp  = 8'(addr[SHIFT +: GRP_W]);
            end
        end
    end
endmodule

// File: rtl/msi_idx_reg.sv
module msi_idx_reg #(
    parameter int VEC = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   set_en,
    input  logic [$clog2(VEC)-1:0] set_bit,
    input  logic                   clr_en,
    output logic [VEC-1:0]         q
);
    logic [VEC-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        if (set_en) set_mask[set_bit] = 1'b1;
    end

    // A clear drops only the old contents; a same-cycle set survives
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (clr_en ? '0 : q) | set_mask;
    end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int IDX = 8,
    parameter int VEC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IDX-1:0]           set_sel,
    input  logic [$clog2(VEC)-1:0]   set_bit,
    input  logic [IDX-1:0]           clr_sel,
    output logic [IDX-1:0][VEC-1:0]  regs_q,
    output logic [IDX-1:0]           summary,
    output logic                     irq
);
    for (genvar x = 0; x < IDX; x++) begin : g_idx
        msi_idx_reg #(.VEC(VEC)) i_reg (
            .clk    (clk),
            .rst    (rst),
            .set_en (set_sel[x]),
            .set_bit(set_bit),
            .clr_en (clr_sel[x]),
            .q      (regs_q[x])
        );
        assign summary[x] = |regs_q[x];
    end

    assign irq = |summary;
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
    import msi_term_pkg::*;
#(
    parameter int GROUPS = DEF_GROUPS,
    parameter int IDX    = DEF_IDX,
    parameter int VEC    = DEF_VEC,
    parameter int SHIFT  = DEF_SHIFT,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msi_wr_valid,
    input  logic [ADDR_W-1:0] msi_wr_addr,
    input  logic [DATA_W-1:0] msi_wr_data,
    input  logic              sw_rd_en,
    input  logic [ADDR_W-1:0] sw_rd_addr,
    output logic [VEC-1:0]    sw_rd_data,
    output logic [GROUPS-1:0] irq
);
    localparam int BIT_W = $clog2(VEC);

    reg_target_t wr_tgt, rd_tgt;
    logic        wr_hit, rd_idx_hit;
    logic [GROUPS-1:0][IDX-1:0]          set_sel, clr_sel;
    logic [GROUPS-1:0][IDX-1:0][VEC-1:0] pend;
    logic [GROUPS-1:0][IDX-1:0]          summ;
    logic [VEC-1:0]                      rd_next;

    msi_addr_dec #(.ADDR_W(ADDR_W), .GROUPS(GROUPS), .IDX(IDX), .SHIFT(SHIFT))
        i_wr_dec (.addr(msi_wr_addr), .tgt(wr_tgt));

    msi_addr_dec #(.ADDR_W(ADDR_W), .GROUPS(GROUPS), .IDX(IDX), .SHIFT(SHIFT))
        i_rd_dec (.addr(sw_rd_addr), .tgt(rd_tgt));

    assign wr_hit     = msi_wr_valid && (wr_tgt.kind == REG_INDEX)
                        && (msi_wr_data < DATA_W'(VEC));
    assign rd_idx_hit = sw_rd_en && (rd_tgt.kind == REG_INDEX);

    always_comb begin
        set_sel = '0;
        clr_sel = '0;
        if (wr_hit)     set_sel[wr_tgt.grp][wr_tgt.idx] = 1'b1;
        if (rd_idx_hit) clr_sel[rd_tgt.grp][rd_tgt.idx] = 1'b1;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        msi_group #(.IDX(IDX), .VEC(VEC)) i_group (
            .clk    (clk),
            .rst    (rst),
            .set_sel(set_sel[g]),
            .set_bit(msi_wr_data[BIT_W-1:0]),
            .clr_sel(clr_sel[g]),
            .regs_q (pend[g]),
            .summary(summ[g]),
            .irq    (irq[g])
        );
    end

    always_comb begin
        rd_next = '0;
        case (rd_tgt.kind)
            REG_INDEX:   rd_next = pend[rd_tgt.grp][rd_tgt.idx];
            REG_SUMMARY: rd_next[IDX-1:0] = summ[rd_tgt.grp];
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           sw_rd_data <= '0;
        else if (sw_rd_en) sw_rd_data <= rd_next;
    end
endmodule

// File: rtl/msi_term_bank_chk.sv
module msi_term_bank_chk #(
    parameter int GROUPS = 16,
    parameter int IDX    = 8,
    parameter int VEC    = 16,
    parameter int SHIFT  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              msi_wr_valid,
    input logic [ADDR_W-1:0] msi_wr_addr,
    input logic [DATA_W-1:0] msi_wr_data,
    input logic              sw_rd_en,
    input logic [ADDR_W-1:0] sw_rd_addr,
    input logic [VEC-1:0]    sw_rd_data,
    input logic [GROUPS-1:0] irq
);
    localparam int GRP_W = $clog2(GROUPS);
    localparam int IDX_W = $clog2(IDX);
    localparam int TOP   = SHIFT + IDX_W + GRP_W;

    logic             wr_ok, rd_is_idx, rd_is_sum;
    logic [GRP_W-1:0] wgrp;

    always_comb begin
        wr_ok = msi_wr_valid && !msi_wr_addr[TOP]
                && ((msi_wr_addr >> (TOP + 1)) == '0)
                && (msi_wr_addr[SHIFT-1:0] == '0)
                && (msi_wr_data < DATA_W'(VEC));
        wgrp  = msi_wr_addr[SHIFT+IDX_W +: GRP_W];
        rd_is_idx = !sw_rd_addr[TOP] && ((sw_rd_addr >> (TOP + 1)) == '0)
                    && (sw_rd_addr[SHIFT-1:0] == '0);
        rd_is_sum = sw_rd_addr[TOP] && ((sw_rd_addr >> (TOP + 1)) == '0)
                    && (sw_rd_addr[SHIFT-1:0] == '0)
                    && (sw_rd_addr[SHIFT+GRP_W +: IDX_W] == '0);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0) && (sw_rd_data == '0));

    // R3
    set_raises_line_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> irq[$past(wgrp)]);

    // R6
    no_spurious_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !msi_wr_valid |=> (irq & ~$past(irq)) == '0);

    // R4
    summary_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rd_en && rd_is_sum |=> (sw_rd_data >> IDX) == '0);

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rd_en && !rd_is_idx && !rd_is_sum |=> sw_rd_data == '0);

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_rd_en |=> $stable(sw_rd_data));
endmodule

bind msi_term_bank msi_term_bank_chk #(
    .GROUPS(GROUPS), .IDX(IDX), .VEC(VEC),
    .SHIFT(SHIFT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_msi_term_bank_chk (
    .clk         (clk),
    .rst         (rst),
    .msi_wr_valid(msi_wr_valid),
    .msi_wr_addr (msi_wr_addr),
    .msi_wr_data (msi_wr_data),
    .sw_rd_en    (sw_rd_en),
    .sw_rd_addr  (sw_rd_addr),
    .sw_rd_data  (sw_rd_data),
    .irq         (irq)
);

// File: tb/test_msi_term_bank.sv
module test_msi_term_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msi_wr_valid = 1'b0;
    logic [23:0] msi_wr_addr = '0;
    logic [31:0] msi_wr_data = '0;
    logic        sw_rd_en = 1'b0;
    logic [23:0] sw_rd_addr = '0;
    logic [15:0] sw_rd_data;
    logic [15:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    msi_term_bank i_msi_term_bank (
        .clk(clk), .rst(rst),
        .msi_wr_valid(msi_wr_valid), .msi_wr_addr(msi_wr_addr),
        .msi_wr_data(msi_wr_data),
        .sw_rd_en(sw_rd_en), .sw_rd_addr(sw_rd_addr),
        .sw_rd_data(sw_rd_data), .irq(irq)
    );

    function automatic logic [23:0] idx_addr(int g, int x);
        return 24'((g << 19) | (x << 16));
    endfunction

    function automatic logic [23:0] sum_addr(int g);
        return 24'(32'h80_0000 | (g << 16));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic msi_wr(logic [23:0] a, logic [31:0] d);
        @(negedge clk);
        msi_wr_valid = 1'b1; msi_wr_addr = a; msi_wr_data = d;
        @(negedge clk);
        msi_wr_valid = 1'b0;
    endtask

    task automatic sw_rd(logic [23:0] a, output logic [15:0] d);
        @(negedge clk);
        sw_rd_en = 1'b1; sw_rd_addr = a;
        @(negedge clk);
        sw_rd_en = 1'b0;
        d = sw_rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rd_data after reset", 32'(sw_rd_data), 32'h0);
        sw_rd(idx_addr(5, 3), d);
        chk("R1 index empty after reset", 32'(d), 32'h0);
        sw_rd(sum_addr(0), d);
        chk("R1 summary empty after reset", 32'(d), 32'h0);
    endtask

    task automatic t_single();
        logic [15:0] d;
        msi_wr(idx_addr(3, 2), 32'd7);
        chk("R6 irq only group 3", 32'(irq), 32'h0008);
        sw_rd(sum_addr(3), d);
        chk("R4 summary g3", 32'(d), 32'h0004);
        sw_rd(idx_addr(3, 2), d);
        chk("R2 R3 index g3 x2 bit 7", 32'(d), 32'h0080);
        chk("R6 irq low after clear", 32'(irq), 32'h0);
        sw_rd(idx_addr(3, 2), d);
        chk("R5 second read empty", 32'(d), 32'h0);
        sw_rd(sum_addr(3), d);
        chk("R4 summary g3 cleared", 32'(d), 32'h0);
    endtask

    task automatic t_multi();
        logic [15:0] d;
        msi_wr(idx_addr(0, 0), 32'd0);
        msi_wr(idx_addr(0, 7), 32'd15);
        msi_wr(idx_addr(15, 7), 32'd15);
        msi_wr(idx_addr(15, 0), 32'd1);
        msi_wr(idx_addr(15, 0), 32'd2);
        chk("R6 irq groups 0 and 15", 32'(irq), 32'h8001);
        sw_rd(sum_addr(0), d);
        chk("R4 summary g0", 32'(d), 32'h0081);
        sw_rd(sum_addr(15), d);
        chk("R4 summary g15", 32'(d), 32'h0081);
        sw_rd(idx_addr(15, 0), d);
        chk("R3 accumulated bits g15 x0", 32'(d), 32'h0006);
        for (int x = 1; x < 8; x++) sw_rd(idx_addr(15, x), d);
        chk("R2 last index g15 x7", 32'(d), 32'h8000);
        sw_rd(sum_addr(15), d);
        chk("R5 group drained", 32'(d), 32'h0);
        chk("R6 irq only group 0", 32'(irq), 32'h0001);
        sw_rd(idx_addr(0, 0), d);
        chk("R2 first index g0 x0", 32'(d), 32'h0001);
        sw_rd(idx_addr(0, 7), d);
        chk("R6 all lines low", 32'(irq), 32'h0);
    endtask

    task automatic t_bad_data();
        logic [15:0] d;
        msi_wr(idx_addr(4, 1), 32'd16);
        msi_wr(idx_addr(4, 1), 32'h100);
        chk("R3 out-of-range data no irq", 32'(irq), 32'h0);
        sw_rd(idx_addr(4, 1), d);
        chk("R3 out-of-range data no bit", 32'(d), 32'h0);
    endtask

    task automatic t_ignored_writes();
        logic [15:0] d;
        msi_wr(sum_addr(2), 32'd3);
        msi_wr(idx_addr(1, 1) | 24'h4, 32'd3);
        msi_wr(24'h90_0000, 32'd3);
        chk("R8 ignored writes no irq", 32'(irq), 32'h0);
        sw_rd(sum_addr(2), d);
        chk("R8 summary write ignored", 32'(d), 32'h0);
        sw_rd(idx_addr(1, 1), d);
        chk("R8 low-bit offset ignored", 32'(d), 32'h0);
    endtask

    task automatic t_unmapped_read();
        logic [15:0] d;
        msi_wr(idx_addr(6, 2), 32'd9);
        sw_rd(24'h90_0000, d);
        chk("R9 unmapped read zero", 32'(d), 32'h0);
        sw_rd(idx_addr(6, 2) | 24'h10, d);
        chk("R9 low-bit read zero", 32'(d), 32'h0);
        chk("R9 pending kept", 32'(irq), 32'h0040);
        sw_rd(idx_addr(6, 2), d);
        chk("R9 contents intact", 32'(d), 32'h0200);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        msi_wr(idx_addr(9, 4), 32'd1);
        @(negedge clk);
        msi_wr_valid = 1'b1; msi_wr_addr = idx_addr(9, 4); msi_wr_data = 32'd5;
        sw_rd_en = 1'b1; sw_rd_addr = idx_addr(9, 4);
        @(negedge clk);
        msi_wr_valid = 1'b0; sw_rd_en = 1'b0;
        chk("R7 collision returns old", 32'(sw_rd_data), 32'h0002);
        chk("R7 collision irq stays", 32'(irq), 32'h0200);
        sw_rd(idx_addr(9, 4), d);
        chk("R7 written bit survives", 32'(d), 32'h0020);
    endtask

    task automatic t_hold();
        msi_wr(idx_addr(12, 5), 32'd11);
        @(negedge clk);
        sw_rd_en = 1'b1; sw_rd_addr = idx_addr(12, 5);
        @(negedge clk);
        sw_rd_en = 1'b0;
        chk("R10 data one edge after request", 32'(sw_rd_data), 32'h0800);
        repeat (3) @(negedge clk);
        chk("R10 data held", 32'(sw_rd_data), 32'h0800);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_bad_data();
        t_ignored_writes();
        t_unmapped_read();
        t_collision();
        t_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule